// File: doc/BRIEF.md
# Command-Stream SPI Host Register Front End

This block is the bus-facing register file of a command-driven SPI host. Software pushes 16-bit command words and 8-bit transmit bytes into two queues. It drains received bytes from a third queue, either by consuming the head or by looking at it without removing it. The command executor on the far side takes commands and transmit bytes from the queue heads with a single-cycle take strobe. It delivers received bytes and completion markers ("sync" events carrying an 8-bit tag) back into the block.

Software also sees a version word and a soft-reset control that holds the executor in reset. It sees the tag of the most recent sync event, the free room of both outbound queues and the fill level of the inbound queue. Four interrupt causes are available: command queue running low, transmit queue running low, receive queue running high, and sync seen. Each cause has an enable bit, a write-one-to-clear pending bit and a masked source view. All causes are combined onto one interrupt line. Bus reads are registered, so data appears on the cycle after the read strobe.

Top module: `cmdspi_regfront`

## Requirements
- R1: A read of address 0x00 returns the version word: major number 1 in bits 23:16, minor in bits 15:8 and patch in bits 7:0. With the default parameters this is 0x00010061. Writes to this address have no effect.
- R2: Bit 0 of the register at 0x40 drives `engine_hold`. It resets to 1, a write of 0 releases the executor, a write of 1 holds it again, and the value reads back at 0x40.
- R3: A write to 0xE0 pushes bits 15:0 into the command queue. The head appears on `cmd_word` with `cmd_valid` high, in push order, and it advances by one on each cycle with `cmd_take` high. A read of 0xD0 returns CMD_DEPTH minus the queue level.
- R4: A write to 0xE4 pushes bits 7:0 into the transmit queue. The head appears on `tx_byte` with `tx_valid` high, in push order, and it advances on `tx_take`. A read of 0xD4 returns TX_DEPTH minus the level.
- R5: The pending register at 0x84 uses the interrupt bit layout: bit 0 command low, bit 1 transmit low, bit 2 receive high, bit 3 sync. Writing a 1 to a bit clears it, and writing 0xFF clears every bit whose cause is no longer present.
- R6: A cycle with `sync_pulse` high stores `sync_tag` in the register read at 0xC0 and sets pending bit 3.
- R7: The enable register at 0x80 (bits 3:0) masks the pending bits. A read of 0x88 returns pending AND enable, and `irq` is high exactly when that value is nonzero.
- R8: The watermark bits are level causes. Bit 0 is set while the command level is at or below CMD_LOW_MARK, bit 1 while the transmit level is at or below TX_LOW_MARK, and bit 2 while the receive level is at or above RX_HIGH_MARK. A cleared bit sets again on the next cycle if its condition still holds.
- R9: A cycle with `rx_put` high pushes `rx_byte` into the receive queue. A read of 0xD8 returns its level. A read of 0xE8 returns the head and removes it. A read of 0xEC returns the head and leaves the queue unchanged.
- R10: A push to a full queue is dropped without changing its contents. A read of 0xE8 or 0xEC while the receive queue is empty returns 0 and changes nothing.
- R11: Read data is registered and appears on `bus_rd_data` one cycle after `bus_rd`. Unmapped addresses read as 0, and writes to them or to read-only addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_wr_addr | input | 8 | Byte address of the write |
| bus_wr_data | input | 32 | Write data |
| bus_rd | input | 1 | Register read strobe |
| bus_rd_addr | input | 8 | Byte address of the read |
| bus_rd_data | output | 32 | Read data, valid the cycle after `bus_rd` |
| cmd_valid | output | 1 | Command queue not empty |
| cmd_word | output | 16 | Command queue head |
| cmd_take | input | 1 | Executor consumes the command head |
| tx_valid | output | 1 | Transmit queue not empty |
| tx_byte | output | 8 | Transmit queue head |
| tx_take | input | 1 | Executor consumes the transmit head |
| rx_put | input | 1 | Executor delivers a received byte |
| rx_byte | input | 8 | Received byte |
| sync_pulse | input | 1 | Sync marker reached by the executor |
| sync_tag | input | 8 | Tag of that sync marker |
| engine_hold | output | 1 | Soft reset for the executor |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest situation to reach from the ports is the race between software clearing a watermark bit and the hardware setting it again. Both happen on the same edge, and the outcome is only visible through a later read. The stimulus writes 0xFF to the pending register while the queues are still below their marks, and the readback shows the bits set again. It then fills the command queue past its mark and clears only bit 0, so the bit stays clear. The receive-high cause is reached by having the executor side deliver more bytes than the queue holds. That run also checks that the surplus bytes are dropped and that the surviving bytes come out in order.

// File: rtl/cmdspi_regs_pkg.sv
package cmdspi_regs_pkg;

    // Byte addresses of the register window
    localparam logic [7:0] A_VERSION  = 8'h00;
    localparam logic [7:0] A_HOLD     = 8'h40;
    localparam logic [7:0] A_IRQ_EN   = 8'h80;
    localparam logic [7:0] A_IRQ_PEND = 8'h84;
    localparam logic [7:0] A_IRQ_SRC  = 8'h88;
    localparam logic [7:0] A_SYNC_TAG = 8'hC0;
    localparam logic [7:0] A_CMD_ROOM = 8'hD0;
    localparam logic [7:0] A_TX_ROOM  = 8'hD4;
    localparam logic [7:0] A_RX_LEVEL = 8'hD8;
    localparam logic [7:0] A_CMD_PUSH = 8'hE0;
    localparam logic [7:0] A_TX_PUSH  = 8'hE4;
    localparam logic [7:0] A_RX_POP   = 8'hE8;
    localparam logic [7:0] A_RX_PEEK  = 8'hEC;

    localparam int IRQ_W = 4;

    // Interrupt causes; the last member lands in bit 0
    typedef struct packed {
        logic sync_seen;
        logic rx_high;
        logic tx_low;
        logic cmd_low;
    } irq_cause_t;

    localparam int MAJOR_VERSION = 1;

    function automatic logic [31:0] pack_version(input logic [7:0] minor_v,
                                                 input logic [7:0] patch_v);
        return {8'h00, 8'(MAJOR_VERSION), minor_v, patch_v};
    endfunction

endpackage

// File: rtl/cmdspi_fifo.sv
module cmdspi_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [$clog2(DEPTH):0] level,
    output logic             full,
    output logic             empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;

    logic [WIDTH-1:0] store [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [LW-1:0]    count;
    logic             do_push, do_pop;

    assign full    = (count == LW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign level   = count;
    assign head    = empty ? '0 : store[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) store[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
            count <= count + LW'(do_push) - LW'(do_pop);
        end
    end

    // R10: a push into a full queue leaves the level untouched
    p_full_drop_r10: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> $stable(level));

    // R10: popping an empty queue keeps it empty
    p_empty_pop_r10: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> empty);

endmodule

// File: rtl/cmdspi_irq.sv
module cmdspi_irq
    import cmdspi_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IRQ_W-1:0] raise,
    input  logic             clr_we,
    input  logic [IRQ_W-1:0] clr_mask,
    input  logic             en_we,
    input  logic [IRQ_W-1:0] en_data,
    output logic [IRQ_W-1:0] pending,
    output logic [IRQ_W-1:0] enable,
    output logic             irq
);
    logic [IRQ_W-1:0] clr_eff;

    assign clr_eff = clr_we ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
            enable  <= '0;
        end else begin
            // a cause present in this cycle wins over a clear
            pending <= (pending & ~clr_eff) | raise;
            if (en_we) enable <= en_data;
        end
    end

    assign irq = |(pending & enable);

    // R6: a sync event always leaves pending bit 3 set
    p_sync_sets_r6: assert property (@(posedge clk) disable iff (rst)
        raise[3] |=> pending[3]);

    // R5: a clear of bit 3 with no new sync empties it
    p_w1c_r5: assert property (@(posedge clk) disable iff (rst)
        (clr_we && clr_mask[3] && !raise[3]) |=> !pending[3]);

endmodule

// File: rtl/cmdspi_regfront.sv
module cmdspi_regfront
    import cmdspi_regs_pkg::*;
#(
    parameter int         CMD_DEPTH    = 8,
    parameter int         TX_DEPTH     = 8,
    parameter int         RX_DEPTH     = 8,
    parameter int         CMD_LOW_MARK = 2,
    parameter int         TX_LOW_MARK  = 2,
    parameter int         RX_HIGH_MARK = 6,
    parameter logic [7:0] VER_MINOR    = 8'h00,
    parameter logic [7:0] VER_PATCH    = 8'h61
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wr_addr,
    input  logic [31:0] bus_wr_data,
    input  logic        bus_rd,
    input  logic [7:0]  bus_rd_addr,
    output logic [31:0] bus_rd_data,
    output logic        cmd_valid,
    output logic [15:0] cmd_word,
    input  logic        cmd_take,
    output logic        tx_valid,
    output logic [7:0]  tx_byte,
    input  logic        tx_take,
    input  logic        rx_put,
    input  logic [7:0]  rx_byte,
    input  logic        sync_pulse,
    input  logic [7:0]  sync_tag,
    output logic        engine_hold,
    output logic        irq
);
    localparam int CLW = $clog2(CMD_DEPTH) + 1;
    localparam int TLW = $clog2(TX_DEPTH) + 1;
    localparam int RLW = $clog2(RX_DEPTH) + 1;
    localparam logic [31:0] VERSION_WORD = pack_version(VER_MINOR, VER_PATCH);

    logic [CLW-1:0] cmd_level;
    logic [TLW-1:0] tx_level;
    logic [RLW-1:0] rx_level;
    logic           cmd_full, cmd_empty, tx_full, tx_empty, rx_full, rx_empty;
    logic [7:0]     rx_head;
    logic           cmd_push, tx_push, rx_pop;
    logic [7:0]     sync_tag_q;
    logic           hold_q;
    irq_cause_t     cause;
    logic [IRQ_W-1:0] pend, irq_en;
    logic [31:0]    rd_next;
    logic           unused_wbits;

    assign unused_wbits = ^bus_wr_data[31:16];

    assign cmd_push = bus_wr && (bus_wr_addr == A_CMD_PUSH);
    assign tx_push  = bus_wr && (bus_wr_addr == A_TX_PUSH);
    assign rx_pop   = bus_rd && (bus_rd_addr == A_RX_POP);

    cmdspi_fifo #(.WIDTH(16), .DEPTH(CMD_DEPTH)) u_cmd_q (
        .clk(clk), .rst(rst), .push(cmd_push), .push_data(bus_wr_data[15:0]),
        .pop(cmd_take), .head(cmd_word), .level(cmd_level),
        .full(cmd_full), .empty(cmd_empty));

    cmdspi_fifo #(.WIDTH(8), .DEPTH(TX_DEPTH)) u_tx_q (
        .clk(clk), .rst(rst), .push(tx_push), .push_data(bus_wr_data[7:0]),
        .pop(tx_take), .head(tx_byte), .level(tx_level),
        .full(tx_full), .empty(tx_empty));

    cmdspi_fifo #(.WIDTH(8), .DEPTH(RX_DEPTH)) u_rx_q (
        .clk(clk), .rst(rst), .push(rx_put), .push_data(rx_byte),
        .pop(rx_pop), .head(rx_head), .level(rx_level),
        .full(rx_full), .empty(rx_empty));

    assign cmd_valid = !cmd_empty;
    assign tx_valid  = !tx_empty;

    always_comb begin
        cause           = '0;
        cause.cmd_low   = int'(cmd_level) <= CMD_LOW_MARK;
        cause.tx_low    = int'(tx_level) <= TX_LOW_MARK;
        cause.rx_high   = int'(rx_level) >= RX_HIGH_MARK;
        cause.sync_seen = sync_pulse;
    end

    cmdspi_irq u_irq (
        .clk(clk), .rst(rst), .raise(cause),
        .clr_we(bus_wr && (bus_wr_addr == A_IRQ_PEND)),
        .clr_mask(bus_wr_data[IRQ_W-1:0]),
        .en_we(bus_wr && (bus_wr_addr == A_IRQ_EN)),
        .en_data(bus_wr_data[IRQ_W-1:0]),
        .pending(pend), .enable(irq_en), .irq(irq));

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q     <= 1'b1;
            sync_tag_q <= '0;
        end else begin
            if (bus_wr && (bus_wr_addr == A_HOLD)) hold_q <= bus_wr_data[0];
            if (sync_pulse) sync_tag_q <= sync_tag;
        end
    end

    assign engine_hold = hold_q;

    always_comb begin
        case (bus_rd_addr)
            A_VERSION:  rd_next = VERSION_WORD;
            A_HOLD:     rd_next = {31'd0, hold_q};
            A_IRQ_EN:   rd_next = 32'(irq_en);
            A_IRQ_PEND: rd_next = 32'(pend);
            A_IRQ_SRC:  rd_next = 32'(pend & irq_en);
            A_SYNC_TAG: rd_next = 32'(sync_tag_q);
            A_CMD_ROOM: rd_next = 32'(CMD_DEPTH) - 32'(cmd_level);
            A_TX_ROOM:  rd_next = 32'(TX_DEPTH) - 32'(tx_level);
            A_RX_LEVEL: rd_next = 32'(rx_level);
            A_RX_POP,
            A_RX_PEEK:  rd_next = 32'(rx_head);
            default:    rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rd_data <= '0;
        else if (bus_rd) bus_rd_data <= rd_next;
    end

    // R6: the stored tag follows the tag of the last sync event
    p_sync_tag_r6: assert property (@(posedge clk) disable iff (rst)
        sync_pulse |=> (sync_tag_q == $past(sync_tag)));

    // R9: a peek leaves the receive level alone
    p_peek_keeps_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_rd_addr == A_RX_PEEK && !rx_put) |=> $stable(rx_level));

    // R7: with every cause masked the line stays low
    p_masked_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (irq_en == '0) |-> !irq);

    // R11: read data only moves after a read strobe
    p_rd_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rd_data));

endmodule

// File: tb/test_cmdspi_regfront.sv
`timescale 1ns/1ps
module test_cmdspi_regfront;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wr_addr = '0;
    logic [31:0] bus_wr_data = '0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rd_addr = '0;
    logic [31:0] bus_rd_data;
    logic        cmd_valid, tx_valid, engine_hold, irq;
    logic [15:0] cmd_word;
    logic [7:0]  tx_byte;
    logic        cmd_take = 1'b0, tx_take = 1'b0, rx_put = 1'b0, sync_pulse = 1'b0;
    logic [7:0]  rx_byte = '0, sync_tag = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cmdspi_regfront i_cmdspi_regfront (
        .clk(clk), .rst(rst),
        .bus_wr(bus_wr), .bus_wr_addr(bus_wr_addr), .bus_wr_data(bus_wr_data),
        .bus_rd(bus_rd), .bus_rd_addr(bus_rd_addr), .bus_rd_data(bus_rd_data),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word), .cmd_take(cmd_take),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_take(tx_take),
        .rx_put(rx_put), .rx_byte(rx_byte),
        .sync_pulse(sync_pulse), .sync_tag(sync_tag),
        .engine_hold(engine_hold), .irq(irq));

    // {write, address, data-or-expected, requirement number}
    localparam int NV = 26;
    localparam logic [48:0] VECS [NV] = '{
        {1'b0, 8'h00, 32'h0001_0061, 8'd1},   // R1 version word
        {1'b0, 8'h40, 32'h1,         8'd2},   // R2 hold after reset
        {1'b1, 8'h40, 32'h0,         8'd2},
        {1'b0, 8'h40, 32'h0,         8'd2},   // R2 released
        {1'b0, 8'hD0, 32'd8,         8'd3},   // R3 empty room
        {1'b0, 8'hD4, 32'd8,         8'd4},   // R4 empty room
        {1'b0, 8'hD8, 32'd0,         8'd9},   // R9 empty level
        {1'b0, 8'h84, 32'h3,         8'd8},   // R8 both low marks active
        {1'b1, 8'h84, 32'hFF,        8'd8},
        {1'b0, 8'h84, 32'h3,         8'd8},   // R8 set again at once
        {1'b1, 8'hE0, 32'h1111,      8'd3},
        {1'b1, 8'hE0, 32'h2222,      8'd3},
        {1'b1, 8'hE0, 32'h3333,      8'd3},
        {1'b0, 8'hD0, 32'd5,         8'd3},   // R3 room after 3 pushes
        {1'b1, 8'h84, 32'h1,         8'd5},
        {1'b0, 8'h84, 32'h2,         8'd5},   // R5 bit 0 cleared, stays clear
        {1'b1, 8'h80, 32'hF,         8'd7},
        {1'b0, 8'h88, 32'h2,         8'd7},   // R7 source = pending & enable
        {1'b1, 8'h80, 32'h1,         8'd7},
        {1'b0, 8'h88, 32'h0,         8'd7},   // R7 masked
        {1'b1, 8'h00, 32'hFFFF_FFFF, 8'd11},
        {1'b0, 8'h00, 32'h0001_0061, 8'd11},  // R11 read-only write ignored
        {1'b0, 8'h7C, 32'h0,         8'd11},  // R11 unmapped reads zero
        {1'b1, 8'hE4, 32'h1AB,       8'd4},
        {1'b0, 8'hD4, 32'd7,         8'd4},   // R4 room after a push
        {1'b1, 8'h80, 32'h0,         8'd7}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_wr_addr = a; bus_wr_data = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_rd_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rd_data;
    endtask

    task automatic rx_push(input logic [7:0] b);
        rx_put = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_put = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected finished");
        finish_run();
    end

    initial begin
        logic [31:0] got;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // reset state, R2 R3 R4 R7
        check("R2 hold at reset", 32'(engine_hold), 32'd1);
        check("R7 irq at reset", 32'(irq), 32'd0);
        check("R3 cmd_valid at reset", 32'(cmd_valid), 32'd0);
        check("R4 tx_valid at reset", 32'(tx_valid), 32'd0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i][48]) bus_write(VECS[i][47:40], VECS[i][39:8]);
            else begin
                bus_read(VECS[i][47:40], got);
                check($sformatf("R%0d table %0d", VECS[i][7:0], i), got, VECS[i][39:8]);
            end
        end

        // R3 / R4 executor side order
        check("R3 head valid", 32'(cmd_valid), 32'd1);
        check("R3 first head", 32'(cmd_word), 32'h1111);
        cmd_take = 1'b1; @(negedge clk); cmd_take = 1'b0;
        check("R3 second head", 32'(cmd_word), 32'h2222);
        check("R4 tx head", 32'(tx_byte), 32'hAB);
        tx_take = 1'b1; @(negedge clk); tx_take = 1'b0;
        check("R4 tx drained", 32'(tx_valid), 32'd0);

        // R9 peek and pop, R10 empty pop
        rx_push(8'h11);
        rx_push(8'h22);
        bus_read(8'hD8, got); check("R9 level", got, 32'd2);
        bus_read(8'hEC, got); check("R9 peek", got, 32'h11);
        bus_read(8'hEC, got); check("R9 peek again", got, 32'h11);
        bus_read(8'hD8, got); check("R9 level after peek", got, 32'd2);
        bus_read(8'hE8, got); check("R9 pop first", got, 32'h11);
        bus_read(8'hE8, got); check("R9 pop second", got, 32'h22);
        bus_read(8'hE8, got); check("R10 pop empty", got, 32'h0);
        bus_read(8'hEC, got); check("R10 peek empty", got, 32'h0);
        bus_read(8'hD8, got); check("R10 level after empty pop", got, 32'd0);

        // R10 overflow drop, R8 receive high mark
        for (int i = 0; i < 10; i++) rx_push(8'(i * 3 + 1));
        bus_read(8'hD8, got); check("R10 level capped", got, 32'd8);
        bus_read(8'h84, got); check("R8 rx high bit", got & 32'h4, 32'h4);
        for (int i = 0; i < 8; i++) begin
            bus_read(8'hE8, got);
            check("R10 surviving order", got, 32'(i * 3 + 1));
        end

        // R10 command queue overflow
        for (int i = 0; i < 10; i++) bus_write(8'hE0, 32'(16'h4000 + i));
        bus_read(8'hD0, got); check("R10 cmd room at full", got, 32'd0);

        // R6 sync tag and pending, R7 irq line, R5 clear
        sync_tag = 8'h5A; sync_pulse = 1'b1; @(negedge clk); sync_pulse = 1'b0;
        bus_read(8'hC0, got); check("R6 sync tag", got, 32'h5A);
        bus_read(8'h84, got); check("R6 sync pending", got & 32'h8, 32'h8);
        check("R7 irq masked", 32'(irq), 32'd0);
        bus_write(8'h80, 32'h8);
        check("R7 irq raised", 32'(irq), 32'd1);
        bus_write(8'h84, 32'h8);
        check("R5 irq after clear", 32'(irq), 32'd0);
        sync_tag = 8'hA5; sync_pulse = 1'b1; @(negedge clk); sync_pulse = 1'b0;
        bus_read(8'hC0, got); check("R6 second tag", got, 32'hA5);
        check("R7 irq second sync", 32'(irq), 32'd1);

        // R2 hold again
        bus_write(8'h40, 32'h1);
        check("R2 hold set", 32'(engine_hold), 32'd1);
        bus_write(8'h40, 32'h0);
        check("R2 hold cleared", 32'(engine_hold), 32'd0);

        // reset mid-run
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R2 hold after reset", 32'(engine_hold), 32'd1);
        check("R7 irq after reset", 32'(irq), 32'd0);
        check("R3 queue flushed", 32'(cmd_valid), 32'd0);
        bus_read(8'hD0, got); check("R3 room after reset", got, 32'd8);
        bus_read(8'hC0, got); check("R6 tag after reset", got, 32'h0);

        finish_run();
    end

endmodule